// File: doc/BRIEF.md
# PCI Target Write-Burst Receiver

This block sits on the application side of an embedded PCI core and drains posted target writes from the core's write-data FIFO port. When the core raises a write request, the block acknowledges the command/address phase, captures the target address and the burst flag, and then paces a data phase with its own data-enable strobe. Each complete 32-bit word goes out on a local memory write port with its byte enables, and the address steps by one word for each write.

A static mode input selects between two bus layouts. In wide mode the full 32-bit bus carries the address and the data words, and a 4-bit sideband carries the byte enables. In narrow mode only the low 16 bits carry payload. Addresses and data words arrive lower half first, and the block rebuilds the 32-bit values. If the FIFO runs dry, the block pauses without losing any half-word. The burst ends on the core's active-low last-cycle marker.

Top module: `pci_wr_burst_rx`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after reset, `addr_ack_no` and `data_en_no` are 1 and `mem_we_o` is 0.
- R2: When `wr_req_ni` is sampled low while the block is idle, `addr_ack_no` goes low in the next cycle. It stays low for one cycle in wide mode. In narrow mode it stays low until an address piece with `last_ni` low has been taken, or until two pieces have been taken.
- R3: `data_en_no` is low only while `fifo_empty_ni` is 1. It is never low in the same cycle as `addr_ack_no`.
- R4: In wide mode the address is `data_i` in its acknowledged cycle, and `be_i[1]` in that cycle is the burst flag (1 = burst). Each cycle with `data_en_no` low delivers one word, taken from `data_i`, with byte enables taken from `be_i`.
- R5: In narrow mode the first address piece supplies address bits 15:0 from `data_i[15:0]`, and a second piece supplies bits 31:16. If the first piece carries `last_ni` low, the upper address bits are zero.
- R6: In narrow mode `data_i[17]` of the first address piece is the burst flag.
- R7: In narrow mode each word takes two enabled cycles: bits 15:0 come first and bits 31:16 second, both on `data_i[15:0]`. The word's byte enables are the `be_i` of the second half.
- R8: The first word is written to the captured address, and each later word of the same burst to the previous address plus 4.
- R9: When an item with `last_ni` low is taken in the data phase, `data_en_no` is 1 in the next cycle. A non-burst access ends after exactly one word, even if `last_ni` is not asserted.
- R10: Cycles with `fifo_empty_ni` at 0 take no data. A half-word already received is kept until its partner arrives, so no half is lost or repeated.
- R11: `mem_we_o` pulses for one cycle, one cycle after the clock edge that takes a word's final item. `mem_addr_o`, `mem_data_o` and `mem_be_o` are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| narrow_i | input | 1 | Static mode select: 1 = 16-bit halves, 0 = 32-bit |
| wr_req_ni | input | 1 | Write command/address pending, active low |
| fifo_empty_ni | input | 1 | Write FIFO empty, active low (1 = data available) |
| last_ni | input | 1 | Last item of the current phase, active low |
| data_i | input | 32 | Address/data bus from the core |
| be_i | input | 4 | Byte enables, or burst flag in bit 1 during the wide address phase |
| addr_ack_no | output | 1 | Address phase acknowledge, active low |
| data_en_no | output | 1 | Write data enable, active low |
| mem_we_o | output | 1 | Local write strobe |
| mem_addr_o | output | 32 | Local write address |
| mem_data_o | output | 32 | Local write data |
| mem_be_o | output | 4 | Local write byte enables |

## Verification
The embedded properties watch the strobe rules on every cycle: the enable never runs against an empty FIFO or overlaps the acknowledge, the enable is released after the last marker, the acknowledge follows a request, a write follows an enabled take, and a stored half stays unchanged across stall cycles. Only the bench's scenarios can show that words are assembled correctly: address reconstruction in both modes, the burst flag in each layout, the word-by-word address stepping, the end of a non-burst access without a marker, and the exact content after random FIFO stalls that fall between halves.

// File: rtl/pci_wr_rx_pkg.sv
package pci_wr_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;
endpackage

// File: rtl/pci_wr_addr_gen.sv
module pci_wr_addr_gen #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              narrow_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [WORD_W-1:0] piece_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] addr_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int STEP   = WORD_W / 8;

  logic [WORD_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (ld_lo_i) begin
      addr_q <= narrow_i ? {{HALF_W{1'b0}}, piece_i[HALF_W-1:0]} : piece_i;
    end else if (ld_hi_i) begin
      addr_q[WORD_W-1:HALF_W] <= piece_i[HALF_W-1:0];
    end else if (step_i) begin
      addr_q <= addr_q + WORD_W'(STEP);
    end
  end

  assign addr_o = addr_q;

  // R8
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_lo_i && !ld_hi_i) |=> addr_q == $past(addr_q) + WORD_W'(STEP));
endmodule

// File: rtl/pci_wr_word_asm.sv
module pci_wr_word_asm #(
  parameter int WORD_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                narrow_i,
  input  logic                take_i,
  input  logic                clear_i,
  input  logic [WORD_W-1:0]   data_i,
  input  logic [WORD_W/8-1:0] be_i,
  output logic                done_o,
  output logic [WORD_W-1:0]   word_o,
  output logic [WORD_W/8-1:0] be_o
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] lo_q;
  logic              have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      have_q <= 1'b0;
    end else if (clear_i) begin
      have_q <= 1'b0;
    end else if (take_i && narrow_i) begin
      if (!have_q) lo_q <= data_i[HALF_W-1:0];
      have_q <= !have_q;
    end
  end

  assign done_o = take_i && (!narrow_i || have_q);
  assign word_o = narrow_i ? {data_i[HALF_W-1:0], lo_q} : data_i;
  assign be_o   = be_i;

  // R10
  half_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !clear_i) |=> ($stable(lo_q) && $stable(have_q)));
endmodule

// File: rtl/pci_wr_burst_rx.sv
module pci_wr_burst_rx
  import pci_wr_rx_pkg::*;
#(
  parameter  int WORD_W = 32,
  localparam int BE_W   = WORD_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              narrow_i,
  input  logic              wr_req_ni,
  input  logic              fifo_empty_ni,
  input  logic              last_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              addr_ack_no,
  output logic              data_en_no,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic [BE_W-1:0]   mem_be_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int BURST_BIT_N = HALF_W + 1;

  rx_state_e st_q;
  logic      apiece_q;
  logic      burst_q;

  logic              in_addr, take, done, txn_end, ld_lo, ld_hi;
  logic [WORD_W-1:0] cur_addr, word;
  logic [BE_W-1:0]   word_be;

  assign in_addr = (st_q == ST_ADDR);
  assign take    = (st_q == ST_DATA) && fifo_empty_ni;
  assign ld_lo   = in_addr && !apiece_q;
  assign ld_hi   = in_addr && apiece_q;
  assign txn_end = take && (!last_ni || (done && !burst_q));

  assign addr_ack_no = !in_addr;
  assign data_en_no  = !take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      apiece_q <= 1'b0;
      burst_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (!wr_req_ni) st_q <= ST_ADDR;
        ST_ADDR: begin
          if (ld_lo) burst_q <= narrow_i ? data_i[BURST_BIT_N] : be_i[1];
          if (!narrow_i || apiece_q || !last_ni) begin
            st_q     <= ST_DATA;
            apiece_q <= 1'b0;
          end else begin
            apiece_q <= 1'b1;
          end
        end
        ST_DATA: if (txn_end) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  pci_wr_addr_gen #(.WORD_W(WORD_W)) addr_gen_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .narrow_i(narrow_i),
    .ld_lo_i (ld_lo),
    .ld_hi_i (ld_hi),
    .piece_i (data_i),
    .step_i  (done),
    .addr_o  (cur_addr)
  );

  pci_wr_word_asm #(.WORD_W(WORD_W)) word_asm_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .narrow_i(narrow_i),
    .take_i  (take),
    .clear_i (txn_end),
    .data_i  (data_i),
    .be_i    (be_i),
    .done_o  (done),
    .word_o  (word),
    .be_o    (word_be)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
      mem_be_o   <= '0;
    end else begin
      mem_we_o <= done;
      if (done) begin
        mem_addr_o <= cur_addr;
        mem_data_o <= word;
        mem_be_o   <= word_be;
      end
    end
  end

  // R3
  en_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_en_no |-> fifo_empty_ni);
  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!data_en_no && !addr_ack_no));
  // R9
  last_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_en_no && !last_ni) |=> data_en_no);
  // R11
  we_after_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(!data_en_no));
  // R2
  ack_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(addr_ack_no) |-> $past(!wr_req_ni));
endmodule

// File: tb/pci_wr_burst_rx_tb.sv
module pci_wr_burst_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        narrow = 1'b0;
  logic        wr_req_n = 1'b1;
  logic        fifo_empty_n = 1'b0;
  logic        last_n = 1'b1;
  logic [31:0] data = '0;
  logic [3:0]  be = '0;
  logic        ack_n, en_n, we;
  logic [31:0] maddr, mdata;
  logic [3:0]  mbe;

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  logic [31:0] exp_addr[$];
  logic [31:0] exp_data[$];
  logic [3:0]  exp_be[$];

  always #5 clk = ~clk;

  pci_wr_burst_rx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .narrow_i(narrow), .wr_req_ni(wr_req_n),
    .fifo_empty_ni(fifo_empty_n), .last_ni(last_n), .data_i(data), .be_i(be),
    .addr_ack_no(ack_n), .data_en_no(en_n), .mem_we_o(we),
    .mem_addr_o(maddr), .mem_data_o(mdata), .mem_be_o(mbe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: every write strobe must match the next expected word
  always @(negedge clk) begin
    if (rst_ni && we) begin
      if (exp_addr.size() == 0) begin
        chk(0, "R10 unexpected write", maddr, 32'h0);
      end else begin
        chk(maddr == exp_addr[0], "R8 address", maddr, exp_addr[0]);
        chk(mdata == exp_data[0], "R7/R4 data", mdata, exp_data[0]);
        chk(mbe == exp_be[0], "R4/R7 byte enables", {28'h0, mbe}, {28'h0, exp_be[0]});
        void'(exp_addr.pop_front());
        void'(exp_data.pop_front());
        void'(exp_be.pop_front());
      end
    end
  end

  task automatic txn(input bit nar, input logic [31:0] a, input bit burst, input int n,
                     input logic [31:0] base, input int stall_pct, input bit omit_last);
    logic [31:0] pd[$];
    logic [3:0]  pb[$];
    bit          pl[$];
    int cyc, k;
    bit got, pend;
    narrow = nar;
    // address pieces
    if (!nar) begin
      pd.push_back(a); pb.push_back({2'b00, burst, 1'b0}); pl.push_back(1'b1);
    end else if (a[31:16] == 16'h0) begin
      pd.push_back({14'h0, burst, 1'b0, a[15:0]}); pb.push_back(4'h0); pl.push_back(1'b0);
    end else begin
      pd.push_back({14'h0, burst, 1'b0, a[15:0]}); pb.push_back(4'h0); pl.push_back(1'b1);
      pd.push_back({14'h0, burst, 1'b0, a[31:16]}); pb.push_back(4'h0); pl.push_back(1'b0);
    end
    k = 0; cyc = 0;
    @(negedge clk);
    wr_req_n = 1'b0;
    while (k < pd.size()) begin
      data = pd[k]; be = pb[k]; last_n = pl[k]; fifo_empty_n = 1'b0;
      #1;
      got = !ack_n;
      cyc++;
      if (k == 0 && cyc <= 2) chk(got == (cyc == 2), "R2 ack latency", {31'h0, got}, {31'h0, cyc == 2});
      chk(en_n == 1'b1, "R3 no enable during address", {31'h0, en_n}, 32'h1);
      @(posedge clk); @(negedge clk);
      if (got) begin k++; wr_req_n = 1'b1; end
    end
    chk(ack_n == 1'b1, "R2 ack released", {31'h0, ack_n}, 32'h1);
    // data items
    pd.delete(); pb.delete(); pl.delete();
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      logic [3:0] wb;
      w = base + i * 32'h0103_0507;
      wb = 4'(4'hF - i);
      exp_addr.push_back(a + 32'(4 * i)); exp_data.push_back(w); exp_be.push_back(wb);
      if (nar) begin
        pd.push_back({16'hDEAD, w[15:0]}); pb.push_back(4'h0); pl.push_back(1'b1);
        pd.push_back({16'hBEEF, w[31:16]}); pb.push_back(wb);
        pl.push_back(!(i == n - 1) || omit_last);
      end else begin
        pd.push_back(w); pb.push_back(wb); pl.push_back(!(i == n - 1) || omit_last);
      end
    end
    k = 0; pend = 0;
    while (k < pd.size()) begin
      fifo_empty_n = ($urandom_range(0, 99) < stall_pct) ? 1'b0 : 1'b1;
      data = pd[k]; be = pb[k]; last_n = pl[k];
      #1;
      got = !en_n;
      if (!fifo_empty_n) chk(en_n == 1'b1, "R3/R10 enable while empty", {31'h0, en_n}, 32'h1);
      @(posedge clk); @(negedge clk);
      if (pend) chk(1'b0, "R11 write missing", 32'h0, 32'h1);
      pend = 0;
      if (got) begin
        if (!nar || k[0]) begin
          chk(we == 1'b1, "R11 write one cycle after final item", {31'h0, we}, 32'h1);
        end
        k++;
      end
    end
    fifo_empty_n = 1'b1; last_n = 1'b1; data = 32'h0; be = 4'h0;
    #1;
    chk(en_n == 1'b1, "R9 enable released after last", {31'h0, en_n}, 32'h1);
    repeat (3) @(negedge clk);
    chk(exp_addr.size() == 0, "R9/R10 word count", 32'(exp_addr.size()), 32'h0);
    fifo_empty_n = 1'b0;
  endtask

  initial begin
    #3;
    chk(ack_n && en_n && !we, "R1 reset strobes", {29'h0, ack_n, en_n, we}, 32'h6);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(ack_n && en_n && !we, "R1 first cycle after reset", {29'h0, ack_n, en_n, we}, 32'h6);
    // R4 R8 wide burst with stalls
    txn(1'b0, 32'h1000_0040, 1'b1, 4, 32'hA000_0001, 30, 1'b0);
    // R4 R9 wide single with marker
    txn(1'b0, 32'h0000_2000, 1'b0, 1, 32'h1234_5678, 0, 1'b0);
    // R9 wide single without marker: ends after one word
    txn(1'b0, 32'h0000_3004, 1'b0, 1, 32'h8765_4321, 0, 1'b1);
    // R5 R6 R7 R10 narrow burst, two-piece address, stalls between halves
    txn(1'b1, 32'h2345_0010, 1'b1, 3, 32'hC0DE_0000, 40, 1'b0);
    // R5 narrow single-piece address, non-burst
    txn(1'b1, 32'h0000_8000, 1'b0, 1, 32'h5A5A_A5A5, 0, 1'b0);
    // R10 narrow burst under heavy stalling
    txn(1'b1, 32'h00F0_0100, 1'b1, 5, 32'h0BAD_F00D, 70, 1'b0);
    // R4 wide burst, no stalls
    txn(1'b0, 32'hFFFF_FF00, 1'b1, 6, 32'h0000_0010, 0, 1'b0);
    done_run = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done_run) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule